// File: doc/BRIEF.md
# DMA Trigger and Burst Controller

This block decides when a DMA channel may move data, and how much. It sits between a peripheral's trigger wire and the beat-request handshake of one DMA channel. The trigger wire is first brought into the clock domain by a two-stage synchronizer. It is then interpreted according to a selected mode: off, active-low level, active-high level, falling edge or rising edge. When the hardware trigger is off, a one-cycle software pulse can start work instead.

Each accepted trigger opens a burst. A burst is one beat in single mode, or 2^n beats in burst mode. A level trigger keeps opening bursts for as long as it stays active. The channel takes one beat per `beat_done` while `beat_req` is high. On the `beat_done` that finishes a burst, the block pulses `wrap_src` and/or `wrap_dst`, so the address unit can return to the burst base. An edge that arrives during a burst is remembered once and starts the following burst. At the end of a descriptor, signalled by `desc_done`, the burst in progress stops. If `desc_clr_trig` is high at that moment, the remembered trigger is also discarded, so the next descriptor waits for a fresh trigger.

The control is a two-state machine. `ST_IDLE` moves to `ST_BURST` when a trigger fires: a remembered event, a fresh edge, a software pulse, or an active level. It loads the beat counter on the way. `ST_BURST` moves back to `ST_IDLE` in two cases: on the final `beat_done` of the burst (burst complete), or on `desc_done` (descriptor end). All other cycles hold the state.

Top module: `dma_trig_burst_ctl`

## Requirements
- R1: After reset, `beat_req`, `wrap_src` and `wrap_dst` are low, and no burst starts until a trigger occurs.
- R2: `cfg_mode` encodes 0 = off, 1 = active-low level, 2 = active-high level, 3 = falling edge, 4 = rising edge; codes 5 to 7 act as off. In an edge mode, a qualifying edge on `trig_in` raises `beat_req` after the third rising clock edge following the change. The opposite edge starts nothing, and an inactive level starts nothing.
- R3: In a level mode, bursts repeat while the level is active, with exactly one idle cycle between them. Once the level has gone inactive, no further bursts start.
- R4: With `cfg_burst_en` = 0, every burst is exactly one beat.
- R5: With `cfg_burst_en` = 1, a burst is 2^`cfg_burst_code` beats. Codes above 10 are clamped to 10, giving 1024 beats.
- R6: With `cfg_mode` = 0, a `sw_trig` pulse raises `beat_req` after the next clock edge. In modes 1 to 4, `sw_trig` is ignored.
- R7: Any number of qualifying edges during a burst are recorded as one event. They yield exactly one more burst, which starts one cycle after the current burst ends.
- R8: `desc_done` together with `desc_clr_trig` discards a recorded event. `desc_done` with `desc_clr_trig` low keeps the event, and the event starts a burst one cycle later.
- R9: `desc_done` during a burst drops `beat_req` after the next clock edge.
- R10: `wrap_src` follows `cfg_wrap[0]` and `wrap_dst` follows `cfg_wrap[1]`. Each pulses only in the cycle of the `beat_done` that completes a burst.
- R11: `beat_req` stays high without `beat_done` until the burst's beats are done or the descriptor ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous peripheral trigger |
| sw_trig | input | 1 | Software trigger pulse (used only in mode 0) |
| cfg_mode | input | 3 | Trigger mode code (see R2) |
| cfg_burst_en | input | 1 | 0 = single beat, 1 = power-of-two burst |
| cfg_burst_code | input | CODE_W (4) | Burst size exponent |
| cfg_wrap | input | 2 | Bit 0 = source wrap, bit 1 = destination wrap |
| desc_clr_trig | input | 1 | Discard recorded trigger at descriptor end |
| desc_done | input | 1 | Current descriptor finished |
| beat_done | input | 1 | Channel completed one beat |
| beat_req | output | 1 | Beat request to the channel |
| wrap_src | output | 1 | Source burst-wrap pulse |
| wrap_dst | output | 1 | Destination burst-wrap pulse |

## Verification
The bench uses the default build, with MAX_CODE = 10 and SYNC_STAGES = 2. This makes the full 1024-beat burst and the clamp of codes 11 to 15 reachable within a single run. With two synchronizer stages, the three-edge trigger latency is a fixed value that can be checked exactly. The 4-bit code port covers every clamped value. Random bursts use exponents 0 to 6, with random beat-done gaps and wrap settings, so that counter reload and the last-beat wrap timing are exercised many times.

// File: rtl/dtb_pkg.sv
`timescale 1ns/1ps
package dtb_pkg;
    typedef enum logic [2:0] {
        TM_OFF  = 3'd0,
        TM_LOW  = 3'd1,
        TM_HIGH = 3'd2,
        TM_FALL = 3'd3,
        TM_RISE = 3'd4
    } trig_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;
endpackage

// File: rtl/dtb_trig_cond.sv
`timescale 1ns/1ps
module dtb_trig_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [2:0] mode,
    output logic       hw_edge,
    output logic       level_act,
    output logic       hw_en
);
    import dtb_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   trig_s;
    logic                   trig_d;

    // synchronizer chain, length picked by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= trig_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            end
        end
    endgenerate

    assign trig_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig_s;
    end

    always_comb begin
        hw_edge   = 1'b0;
        level_act = 1'b0;
        hw_en     = 1'b1;
        case (mode)
            TM_LOW:  level_act = ~trig_s;
            TM_HIGH: level_act = trig_s;
            TM_FALL: hw_edge   = ~trig_s & trig_d;
            TM_RISE: hw_edge   = trig_s & ~trig_d;
            default: hw_en     = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtb_beat_ctr.sv
`timescale 1ns/1ps
module dtb_beat_ctr #(
    parameter int MAX_CODE = 10,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              burst_en,
    input  logic [CODE_W-1:0] code,
    input  logic              dec,
    output logic              last
);
    localparam int CNT_W = MAX_CODE + 1;

    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt_q;

    always_comb begin
        eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        load_val = burst_en ? ((CNT_W'(1) << eff_code) - CNT_W'(1)) : '0;
    end

    // holds beats remaining minus one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/dma_trig_burst_ctl.sv
`timescale 1ns/1ps
module dma_trig_burst_ctl #(
    parameter int MAX_CODE    = 10,
    parameter int SYNC_STAGES = 2,
    localparam int CODE_W     = $clog2(MAX_CODE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              sw_trig,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_burst_en,
    input  logic [CODE_W-1:0] cfg_burst_code,
    input  logic [1:0]        cfg_wrap,
    input  logic              desc_clr_trig,
    input  logic              desc_done,
    input  logic              beat_done,
    output logic              beat_req,
    output logic              wrap_src,
    output logic              wrap_dst
);
    import dtb_pkg::*;

    burst_state_e state_q, state_d;
    logic hw_edge, level_act, hw_en;
    logic pend_q, pend_d;
    logic event_now, fire, take, last, dec, burst_end, clr;

    dtb_trig_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .mode      (cfg_mode),
        .hw_edge   (hw_edge),
        .level_act (level_act),
        .hw_en     (hw_en)
    );

    dtb_beat_ctr #(.MAX_CODE(MAX_CODE), .CODE_W(CODE_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .burst_en (cfg_burst_en),
        .code     (cfg_burst_code),
        .dec      (dec),
        .last     (last)
    );

    assign event_now = hw_edge | (sw_trig & ~hw_en);
    assign fire      = pend_q | event_now | level_act;
    assign clr       = desc_done & desc_clr_trig;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d = ST_BURST;
                    take    = 1'b1;
                end
            end
            ST_BURST: begin
                if (desc_done)              state_d = ST_IDLE;
                else if (beat_done && last) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        beat_req  = (state_q == ST_BURST);
        burst_end = beat_req & beat_done & last;
        dec       = beat_req & beat_done & ~last;
        wrap_src  = burst_end & cfg_wrap[0];
        wrap_dst  = burst_end & cfg_wrap[1];
    end

    // one recorded trigger event; a burst start consumes it
    always_comb begin
        if (clr)       pend_d = 1'b0;
        else if (take) pend_d = 1'b0;
        else           pend_d = pend_q | event_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/dtb_chk.sv
`timescale 1ns/1ps
module dtb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       beat_req,
    input logic       beat_done,
    input logic       desc_done,
    input logic       cfg_burst_en,
    input logic [1:0] cfg_wrap,
    input logic       wrap_src,
    input logic       wrap_dst
);
    AST_WRAP_SRC_AT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_src |-> (beat_req && beat_done && cfg_wrap[0])); // R10
    AST_WRAP_DST_AT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_dst |-> (beat_req && beat_done && cfg_wrap[1])); // R10
    AST_DESC_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req && desc_done) |=> !beat_req); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req && !beat_done && !desc_done) |=> beat_req); // R11
    AST_SINGLE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req && beat_done && !cfg_burst_en && $stable(cfg_burst_en)) |=> !beat_req); // R4
endmodule

bind dma_trig_burst_ctl dtb_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_req     (beat_req),
    .beat_done    (beat_done),
    .desc_done    (desc_done),
    .cfg_burst_en (cfg_burst_en),
    .cfg_wrap     (cfg_wrap),
    .wrap_src     (wrap_src),
    .wrap_dst     (wrap_dst)
);

// File: tb/test_dma_trig_burst_ctl.sv
`timescale 1ns/1ps
module test_dma_trig_burst_ctl;
    localparam int MAXC = 10;
    localparam int CW   = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0, sw_trig = 1'b0;
    logic [2:0]    cfg_mode = 3'd0;
    logic          cfg_burst_en = 1'b0;
    logic [CW-1:0] cfg_burst_code = '0;
    logic [1:0]    cfg_wrap = 2'b00;
    logic          desc_clr_trig = 1'b0, desc_done = 1'b0, beat_done = 1'b0;
    logic          beat_req, wrap_src, wrap_dst;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dma_trig_burst_ctl #(.MAX_CODE(MAXC), .SYNC_STAGES(2)) i_dma_trig_burst_ctl (.*);

    function automatic int exp_len(input bit en, input int code);
        return en ? (1 << ((code > MAXC) ? MAXC : code)) : 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R11 watchdog", 1, 0);
        finish_run();
    end

    task automatic wait_req(input int max, output int lat);
        lat = 0;
        while (!beat_req && lat < max) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic quiet(input int n, input string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (beat_req) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic serve(input int exp, input bit ws, input bit wd, input string tag);
        int got = 0, ws_n = 0, wd_n = 0, guard = 0;
        bit bad = 0;
        while (beat_req && guard < 6000) begin
            beat_done = (($urandom % 4) != 0);
            #1;
            if (beat_done) begin
                got++;
                if (wrap_src) begin ws_n++; if (got != exp) bad = 1; end
                if (wrap_dst) begin wd_n++; if (got != exp) bad = 1; end
            end else if (wrap_src || wrap_dst) bad = 1;
            @(negedge clk);
            guard++;
        end
        beat_done = 1'b0;
        chk(got == exp, tag, got, exp);
        chk(ws_n == int'(ws) && wd_n == int'(wd) && !bad, "R10 wrap pulse",
            ws_n * 10 + wd_n, int'(ws) * 10 + int'(wd));
    endtask

    task automatic set_mode(input logic [2:0] m, input logic lvl);
        cfg_mode = 3'd0;
        trig_in  = lvl;
        repeat (5) @(negedge clk);
        cfg_mode = m;
        @(negedge clk);
    endtask

    task automatic sw_pulse;
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    // hold beat_done low for n cycles while counting request drops
    task automatic hold(input int n, inout int drops);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!beat_req) drops++;
        end
    endtask

    initial begin
        int lat;
        int drops;
        process::self().srandom(32'd20240611);
        repeat (4) @(negedge clk);
        chk(beat_req == 0 && wrap_src == 0 && wrap_dst == 0, "R1 in reset", beat_req, 0);
        rst_n = 1'b1;
        chk(beat_req == 0, "R1 after reset", beat_req, 0);
        quiet(10, "R1 no trigger");

        // software trigger, single beat, both wraps
        cfg_wrap = 2'b11;
        sw_pulse();
        chk(beat_req == 1, "R6 sw start", beat_req, 1);
        serve(1, 1, 1, "R4 single beat");
        quiet(8, "R4 one burst only");

        // software trigger ignored with hardware mode on
        set_mode(3'd4, 1'b0);
        sw_pulse();
        quiet(10, "R6 sw ignored");

        // rising edge, 8-beat burst, source wrap only
        cfg_burst_en = 1'b1; cfg_burst_code = 4'd3; cfg_wrap = 2'b01;
        trig_in = 1'b1;
        wait_req(10, lat);
        chk(lat == 3, "R2 rise latency", lat, 3);
        serve(8, 1, 0, "R5 burst of 8");
        trig_in = 1'b0;
        quiet(10, "R2 opposite edge");

        // falling edge, single, destination wrap only
        cfg_burst_en = 1'b0; cfg_wrap = 2'b10;
        set_mode(3'd3, 1'b1);
        trig_in = 1'b0;
        wait_req(10, lat);
        chk(lat == 3, "R2 fall latency", lat, 3);
        serve(1, 0, 1, "R4 falling single");
        quiet(8, "R4 fall one beat");

        // clamp: code 13 gives 1024 beats
        set_mode(3'd0, 1'b0);
        cfg_burst_en = 1'b1; cfg_burst_code = 4'd13; cfg_wrap = 2'b00;
        sw_pulse();
        serve(exp_len(1'b1, 13), 0, 0, "R5 clamp 1024");
        quiet(6, "R5 clamp end");

        // edges during a burst counted once
        cfg_burst_code = 4'd2;
        set_mode(3'd4, 1'b0);
        trig_in = 1'b1;
        wait_req(10, lat);
        drops = 0;
        trig_in = 1'b0; hold(3, drops);
        trig_in = 1'b1; hold(3, drops);
        trig_in = 1'b0; hold(3, drops);
        trig_in = 1'b1; hold(6, drops);
        chk(drops == 0, "R11 held without beat_done", drops, 0);
        serve(4, 0, 0, "R7 first burst");
        wait_req(3, lat);
        chk(lat == 1, "R7 latched restart", lat, 1);
        serve(4, 0, 0, "R7 second burst");
        quiet(15, "R7 not counted twice");

        // descriptor end with clear-trigger
        trig_in = 1'b0; repeat (5) @(negedge clk);
        trig_in = 1'b1;
        wait_req(10, lat);
        drops = 0;
        trig_in = 1'b0; hold(3, drops);
        trig_in = 1'b1; hold(5, drops);
        desc_done = 1'b1; desc_clr_trig = 1'b1;
        @(negedge clk);
        desc_done = 1'b0; desc_clr_trig = 1'b0;
        chk(beat_req == 0, "R9 descriptor end", beat_req, 0);
        quiet(15, "R8 cleared event");

        // descriptor end without clear-trigger
        trig_in = 1'b0; repeat (5) @(negedge clk);
        trig_in = 1'b1;
        wait_req(10, lat);
        trig_in = 1'b0; hold(3, drops);
        trig_in = 1'b1; hold(5, drops);
        desc_done = 1'b1;
        @(negedge clk);
        desc_done = 1'b0;
        chk(beat_req == 0, "R9 descriptor end keep", beat_req, 0);
        wait_req(3, lat);
        chk(lat == 1, "R8 event persists", lat, 1);
        serve(4, 0, 0, "R8 persisted burst");
        quiet(10, "R8 single persisted burst");

        // high level: repeated bursts of 2
        cfg_burst_code = 4'd1;
        set_mode(3'd2, 1'b0);
        trig_in = 1'b1;
        wait_req(10, lat);
        chk(lat == 3, "R3 level latency", lat, 3);
        for (int b = 0; b < 3; b++) begin
            serve(2, 0, 0, "R3 level burst");
            chk(beat_req == 0, "R3 idle gap", beat_req, 0);
            wait_req(3, lat);
            chk(lat == 1, "R3 restart after gap", lat, 1);
        end
        trig_in = 1'b0;
        for (int b = 0; b < 4; b++) begin
            if (beat_req) serve(2, 0, 0, "R3 drain burst");
            wait_req(3, lat);
        end
        quiet(15, "R3 stops when inactive");

        // low level
        set_mode(3'd1, 1'b1);
        quiet(8, "R2 inactive level");
        trig_in = 1'b0;
        wait_req(10, lat);
        chk(lat == 3, "R3 low level latency", lat, 3);
        trig_in = 1'b1;
        for (int b = 0; b < 4; b++) begin
            if (beat_req) serve(2, 0, 0, "R3 low level burst");
            wait_req(3, lat);
        end
        quiet(15, "R3 low level stops");

        // unused mode code acts as off
        set_mode(3'd6, 1'b0);
        trig_in = 1'b1;
        quiet(8, "R2 code 6 off");

        // random bursts
        for (int it = 0; it < 40; it++) begin
            int kind = $urandom % 3;
            bit en = 1'($urandom % 2);
            int code = $urandom % 7;
            logic [1:0] wr = 2'($urandom % 4);
            cfg_burst_en = en; cfg_burst_code = CW'(code); cfg_wrap = wr;
            if (kind == 0) begin
                set_mode(3'd0, trig_in);
                sw_pulse();
                chk(beat_req == 1, "R6 random sw", beat_req, 1);
            end else begin
                set_mode((kind == 1) ? 3'd4 : 3'd3, (kind == 1) ? 1'b0 : 1'b1);
                trig_in = ~trig_in;
                wait_req(10, lat);
                chk(lat == 3, "R2 random edge", lat, 3);
            end
            serve(exp_len(en, code), wr[0], wr[1], en ? "R5 random burst" : "R4 random single");
            quiet(5, "R7 random no extra");
        end

        finish_run();
    end
endmodule